// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Fault Codes

This block is a fully associative address translation cache. Only software fills it. Each cycle it can accept one lookup, made of a virtual address, a read/write flag and a user/kernel flag. One cycle later it returns either the physical address with an uncached indication, or a fault code that tells the exception logic why translation failed. Page size is 4 KB. A physical address is the frame number of the entry that hits, joined with the 12 offset bits of the virtual address.

Software reaches the slots through three staging registers: a tag register, a data register and a slot-number register. A command port acts on them. It can store the staged pair into the slot named by the slot-number register, or into a slot chosen by a free-running rotation. It can copy a slot back into the staging pair. It can also search for the slot whose tag equals the staged tag. The process-ID field of the tag register is also the current address-space ID used by every lookup. Each entry carries a global flag that makes it match under any process ID. The rotation never picks the lowest slots, so software can pin permanent mappings there.

Top module: `sw_tlb`

## Requirements
- R1: After reset, rsp_valid is 0 and the tag, data and slot-number registers read 0. Every slot is cleared, so every lookup misses until software loads an entry.
- R2: A lookup presented with lk_valid high gives rsp_valid high on the next clock edge. A cycle without lk_valid gives rsp_valid low and rsp_paddr, rsp_exc and rsp_uncached all 0.
- R3: A user-mode lookup (lk_user=1) with vaddr bit 31 set gives code 1 (address fault). This check takes precedence over all others.
- R4: A slot hits when its VPN (tag bits 25:6) equals vaddr bits 31:12 and either its process ID (tag bits 5:0) equals the tag register's bits 5:0, or its global flag (data bit 0) is set. On a clean hit, rsp_exc is 0 and rsp_paddr is {data bits 23:4, vaddr bits 11:0}.
- R5: When no slot hits, the code is 2 if vaddr bit 31 is 0 (user-segment miss) and 3 if it is 1 (kernel-segment miss).
- R6: When the hitting slot has its valid flag (data bit 1) clear, the lookup gets the same miss code as R5.
- R7: A write lookup (lk_write=1) that hits a valid slot with its writable flag (data bit 2) clear gives code 4. A read lookup of that slot translates normally.
- R8: On a clean hit, rsp_uncached equals the slot's data bit 3. Whenever the code is non-zero, rsp_paddr and rsp_uncached are 0.
- R9: Command 0 stores the tag and data registers into the slot named by slot-number bits 5:0. Command 2 loads the tag and data registers from that slot. Command 2 takes precedence over a direct register write in the same cycle.
- R10: The rotation counter is 63 during reset. It decrements on every clock and goes from 8 back to 63. Command 1 stores the tag and data registers into the slot equal to the counter value in that cycle, so slots 0 to 7 are never chosen.
- R11: Command 3 compares the tag register against all slots, ignoring the valid flag and applying the global rule of R4. On a match, the slot-number register becomes {0, slot}. With no match it becomes 7'h40 (bit 6 set). Command 3 takes precedence over a direct slot-number write in the same cycle.
- R12: When several slots hit, the lowest-numbered one decides the result, for both lookups and searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | 1 = store access |
| lk_user | input | 1 | 1 = user mode |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_exc | output | 3 | 0 ok, 1 address fault, 2 user miss, 3 kernel miss, 4 write to read-only |
| rsp_uncached | output | 1 | Access bypasses the cache |
| cmd_valid | input | 1 | Management command strobe |
| cmd_op | input | 2 | 0 write indexed, 1 write rotated, 2 read indexed, 3 search |
| ehi_we | input | 1 | Direct load of the tag register |
| ehi_wdata | input | 26 | {VPN[19:0], PID[5:0]} |
| elo_we | input | 1 | Direct load of the data register |
| elo_wdata | input | 24 | {PFN[19:0], N, D, V, G} |
| idx_we | input | 1 | Direct load of the slot-number register |
| idx_wdata | input | 6 | Slot number (bit 6 cleared) |
| ehi_q | output | 26 | Tag register |
| elo_q | output | 24 | Data register |
| idx_q | output | 7 | Slot-number register, bit 6 = search failed |

## Verification
A corrupted slot, a stale process ID or a wrong priority choice appears at rsp_paddr or rsp_exc on the clock after the first lookup that touches that slot. A search or read-back command exposes it through idx_q, ehi_q and elo_q one cycle after the command. The rotation counter is not visible directly. A slip of even one position shows up at the first rotated write that is followed by a search, because the slot-number register then holds a different value from the reference. Mixed traffic compared on every cycle shortens the time between an internal fault and its first visible mismatch to a few dozen cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [2:0] {
      EXC_NONE  = 3'd0,
      EXC_ADDR  = 3'd1,
      EXC_UMISS = 3'd2,
      EXC_KMISS = 3'd3,
      EXC_MOD   = 3'd4
   } exc_e;

   typedef enum logic [1:0] {
      OP_WIDX  = 2'd0,
      OP_WRND  = 2'd1,
      OP_READ  = 2'd2,
      OP_PROBE = 2'd3
   } op_e;
endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
   parameter int ENTRIES = 64,
   parameter int WIRED   = 8,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [IW-1:0] rnd
);
   localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);
   localparam logic [IW-1:0] LOW = IW'(WIRED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rnd <= TOP;
      else if (rnd == LOW) rnd <= TOP;
      else                 rnd <= rnd - 1'b1;
   end

   AST_RAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd >= LOW) && (rnd <= TOP));  // R10
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 6
) (
   input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
   input  logic [ENTRIES-1:0][PID_W-1:0] ent_pid,
   input  logic [ENTRIES-1:0]            ent_glb,
   input  logic [VPN_W-1:0]              key_vpn,
   input  logic [PID_W-1:0]              key_pid,
   output logic [ENTRIES-1:0]            hit
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit[i] = (ent_vpn[i] == key_vpn) &&
                      (ent_glb[i] || (ent_pid[i] == key_pid));
   end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N  = 64,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int WIRED   = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int PID_W   = 6,
   parameter int OFF_W   = 12,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int HI_W   = VPN_W + PID_W,
   localparam int LO_W   = PFN_W + 4,
   localparam int VA_W   = VPN_W + OFF_W,
   localparam int PA_W   = PFN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_write,
   input  logic             lk_user,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [2:0]       rsp_exc,
   output logic             rsp_uncached,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic             ehi_we,
   input  logic [HI_W-1:0]  ehi_wdata,
   input  logic             elo_we,
   input  logic [LO_W-1:0]  elo_wdata,
   input  logic             idx_we,
   input  logic [IDX_W-1:0] idx_wdata,
   output logic [HI_W-1:0]  ehi_q,
   output logic [LO_W-1:0]  elo_q,
   output logic [IDX_W:0]   idx_q
);
   // flag positions inside the data word
   localparam int B_G = 0;
   localparam int B_V = 1;
   localparam int B_D = 2;
   localparam int B_N = 3;

   if (WIRED >= ENTRIES || WIRED < 0) begin : g_bad_wired
      $error("sw_tlb: WIRED must lie below ENTRIES");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("sw_tlb: ENTRIES must be at least 2");
   end
   if (OFF_W < 1 || VPN_W < 1) begin : g_bad_split
      $error("sw_tlb: address split is empty");
   end

   logic [HI_W-1:0] hi_mem [ENTRIES];
   logic [LO_W-1:0] lo_mem [ENTRIES];

   logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
   logic [ENTRIES-1:0][PID_W-1:0] ent_pid;
   logic [ENTRIES-1:0]            ent_glb;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_fields
      assign ent_vpn[i] = hi_mem[i][HI_W-1:PID_W];
      assign ent_pid[i] = hi_mem[i][PID_W-1:0];
      assign ent_glb[i] = lo_mem[i][B_G];
   end

   logic [IDX_W-1:0] rnd;
   tlb_rand_ctr #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_rnd (
      .clk(clk), .rst_n(rst_n), .rnd(rnd));

   // lookup path
   logic [VPN_W-1:0]   l_vpn;
   logic               l_seg;
   logic [ENTRIES-1:0] l_match;
   logic               l_hit;
   logic [IDX_W-1:0]   l_idx;

   assign l_vpn = lk_vaddr[VA_W-1:OFF_W];
   assign l_seg = lk_vaddr[VA_W-1];

   tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lmatch (
      .ent_vpn(ent_vpn), .ent_pid(ent_pid), .ent_glb(ent_glb),
      .key_vpn(l_vpn), .key_pid(ehi_q[PID_W-1:0]), .hit(l_match));

   tlb_pick #(.N(ENTRIES)) u_lpick (.req(l_match), .found(l_hit), .idx(l_idx));

   // search path
   logic [ENTRIES-1:0] p_match;
   logic               p_hit;
   logic [IDX_W-1:0]   p_idx;

   tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_pmatch (
      .ent_vpn(ent_vpn), .ent_pid(ent_pid), .ent_glb(ent_glb),
      .key_vpn(ehi_q[HI_W-1:PID_W]), .key_pid(ehi_q[PID_W-1:0]), .hit(p_match));

   tlb_pick #(.N(ENTRIES)) u_ppick (.req(p_match), .found(p_hit), .idx(p_idx));

   // fault classification, priority: address, miss, invalid, modify
   logic [LO_W-1:0] sel_lo;
   exc_e            n_exc;
   logic [PA_W-1:0] n_pa;
   logic            n_unc;

   assign sel_lo = lo_mem[l_idx];

   always_comb begin
      n_exc = EXC_NONE;
      n_pa  = '0;
      n_unc = 1'b0;
      if (lk_user && l_seg)
         n_exc = EXC_ADDR;
      else if (!l_hit || !sel_lo[B_V])
         n_exc = l_seg ? EXC_KMISS : EXC_UMISS;
      else if (lk_write && !sel_lo[B_D])
         n_exc = EXC_MOD;
      else begin
         n_pa  = {sel_lo[LO_W-1:4], lk_vaddr[OFF_W-1:0]};
         n_unc = sel_lo[B_N];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_paddr    <= '0;
         rsp_exc      <= EXC_NONE;
         rsp_uncached <= 1'b0;
      end else if (lk_valid) begin
         rsp_valid    <= 1'b1;
         rsp_paddr    <= n_pa;
         rsp_exc      <= n_exc;
         rsp_uncached <= n_unc;
      end else begin
         rsp_valid    <= 1'b0;
         rsp_paddr    <= '0;
         rsp_exc      <= EXC_NONE;
         rsp_uncached <= 1'b0;
      end
   end

   // management commands
   op_e              op;
   logic             do_wr;
   logic             do_rd;
   logic             do_pr;
   logic [IDX_W-1:0] wr_slot;
   logic [IDX_W-1:0] cur_slot;

   assign op       = op_e'(cmd_op);
   assign cur_slot = idx_q[IDX_W-1:0];
   assign do_wr    = cmd_valid && (op == OP_WIDX || op == OP_WRND);
   assign do_rd    = cmd_valid && (op == OP_READ);
   assign do_pr    = cmd_valid && (op == OP_PROBE);
   assign wr_slot  = (op == OP_WRND) ? rnd : cur_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            hi_mem[i] <= '0;
            lo_mem[i] <= '0;
         end
      end else if (do_wr) begin
         hi_mem[wr_slot] <= ehi_q;
         lo_mem[wr_slot] <= elo_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ehi_q <= '0;
         elo_q <= '0;
         idx_q <= '0;
      end else begin
         if (do_rd)       ehi_q <= hi_mem[cur_slot];
         else if (ehi_we) ehi_q <= ehi_wdata;
         if (do_rd)       elo_q <= lo_mem[cur_slot];
         else if (elo_we) elo_q <= elo_wdata;
         if (do_pr)       idx_q <= p_hit ? {1'b0, p_idx} : {1'b1, {IDX_W{1'b0}}};
         else if (idx_we) idx_q <= {1'b0, idx_wdata};
      end
   end

   AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);  // R2
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid && rsp_exc == EXC_NONE);  // R2
   AST_USER_KSEG: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_user && lk_vaddr[VA_W-1] |=> rsp_exc == EXC_ADDR);  // R3
   AST_NOHIT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !(lk_user && lk_vaddr[VA_W-1]) && !l_hit
      |=> rsp_exc == EXC_UMISS || rsp_exc == EXC_KMISS);  // R5
   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_exc != EXC_NONE |-> rsp_paddr == '0 && !rsp_uncached);  // R8
   AST_PROBE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      do_pr && !p_hit |=> idx_q[IDX_W]);  // R11
   AST_RND_NOT_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_WRND |-> rnd >= IDX_W'(WIRED));  // R10
endmodule

// File: tb/tb_sw_tlb.sv
module tb_sw_tlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_write = 1'b0;
   logic        lk_user = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_exc;
   logic        rsp_uncached;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic        ehi_we = 1'b0;
   logic [25:0] ehi_wdata = '0;
   logic        elo_we = 1'b0;
   logic [23:0] elo_wdata = '0;
   logic        idx_we = 1'b0;
   logic [5:0]  idx_wdata = '0;
   logic [25:0] ehi_q;
   logic [23:0] elo_q;
   logic [6:0]  idx_q;

   always #2.5 clk = ~clk;

   sw_tlb dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc),
      .rsp_uncached(rsp_uncached),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .ehi_we(ehi_we), .ehi_wdata(ehi_wdata), .elo_we(elo_we), .elo_wdata(elo_wdata),
      .idx_we(idx_we), .idx_wdata(idx_wdata),
      .ehi_q(ehi_q), .elo_q(elo_q), .idx_q(idx_q));

   int    total = 0;
   int    bad = 0;
   string tag = "R1";
   bit    started = 1'b0;

   // reference state
   bit [25:0] m_hi [64];
   bit [23:0] m_lo [64];
   bit [25:0] m_ehi;
   bit [23:0] m_elo;
   bit [6:0]  m_idx;
   int        m_rnd;
   bit        e_rv;
   bit [31:0] e_pa;
   bit [2:0]  e_exc;
   bit        e_unc;

   task automatic chk(input string what, input bit [31:0] act, input bit [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int m_find(input bit [19:0] vpn, input bit [5:0] pid);
      for (int i = 0; i < 64; i++)
         if (m_hi[i][25:6] == vpn && (m_hi[i][5:0] == pid || m_lo[i][0])) return i;
      return -1;
   endfunction

   task automatic m_lookup(input bit [31:0] va, input bit wr, input bit usr,
                           output bit [31:0] pa, output bit [2:0] ex, output bit un);
      int f;
      pa = '0; ex = 3'd0; un = 1'b0;
      if (usr && va[31]) begin ex = 3'd1; return; end
      f = m_find(va[31:12], m_ehi[5:0]);
      if (f < 0 || !m_lo[f][1]) begin ex = va[31] ? 3'd3 : 3'd2; return; end
      if (wr && !m_lo[f][2]) begin ex = 3'd4; return; end
      pa = {m_lo[f][23:4], va[11:0]};
      un = m_lo[f][3];
   endtask

   task automatic m_step();
      bit [25:0] o_ehi;
      bit [23:0] o_elo;
      bit [6:0]  o_idx;
      int        f;
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
         m_ehi = '0; m_elo = '0; m_idx = '0; m_rnd = 63;
         e_rv = 0; e_pa = '0; e_exc = '0; e_unc = 0;
         return;
      end
      o_ehi = m_ehi; o_elo = m_elo; o_idx = m_idx;
      if (lk_valid) begin
         e_rv = 1;
         m_lookup(lk_vaddr, lk_write, lk_user, e_pa, e_exc, e_unc);
      end else begin
         e_rv = 0; e_pa = '0; e_exc = '0; e_unc = 0;
      end
      if (cmd_valid && cmd_op == 2'd0) begin
         m_hi[o_idx[5:0]] = o_ehi; m_lo[o_idx[5:0]] = o_elo;
      end
      if (cmd_valid && cmd_op == 2'd1) begin
         m_hi[m_rnd] = o_ehi; m_lo[m_rnd] = o_elo;
      end
      if (cmd_valid && cmd_op == 2'd2) begin
         m_ehi = m_hi[o_idx[5:0]]; m_elo = m_lo[o_idx[5:0]];
      end else begin
         if (ehi_we) m_ehi = ehi_wdata;
         if (elo_we) m_elo = elo_wdata;
      end
      if (cmd_valid && cmd_op == 2'd3) begin
         f = m_find(o_ehi[25:6], o_ehi[5:0]);
         m_idx = (f < 0) ? 7'h40 : 7'(f);
      end else if (idx_we) m_idx = {1'b0, idx_wdata};
      m_rnd = (m_rnd == 8) ? 63 : m_rnd - 1;
   endtask

   always @(posedge clk) begin
      m_step();
      started = 1'b1;
      #2;
      chk("rsp_valid", 32'(rsp_valid), 32'(e_rv));
      chk("rsp_exc", 32'(rsp_exc), 32'(e_exc));
      chk("rsp_paddr", rsp_paddr, e_pa);
      chk("rsp_uncached", 32'(rsp_uncached), 32'(e_unc));
      chk("ehi_q", 32'(ehi_q), 32'(m_ehi));
      chk("elo_q", 32'(elo_q), 32'(m_elo));
      chk("idx_q", 32'(idx_q), 32'(m_idx));
   end

   // stimulus helpers: called at a falling edge, return at a falling edge
   task automatic set_hi(input bit [19:0] vpn, input bit [5:0] pid);
      ehi_we = 1; ehi_wdata = {vpn, pid}; @(negedge clk); ehi_we = 0;
   endtask
   task automatic set_lo(input bit [19:0] pfn, input bit [3:0] fl);
      elo_we = 1; elo_wdata = {pfn, fl}; @(negedge clk); elo_we = 0;
   endtask
   task automatic set_idx(input bit [5:0] s);
      idx_we = 1; idx_wdata = s; @(negedge clk); idx_we = 0;
   endtask
   task automatic cmd(input bit [1:0] o);
      cmd_valid = 1; cmd_op = o; @(negedge clk); cmd_valid = 0;
   endtask
   task automatic put(input bit [5:0] s, input bit [19:0] vpn, input bit [5:0] pid,
                      input bit [19:0] pfn, input bit [3:0] fl);
      set_hi(vpn, pid); set_lo(pfn, fl); set_idx(s); cmd(2'd0);
   endtask
   task automatic look(input bit [31:0] va, input bit wr, input bit usr);
      lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = usr;
      @(negedge clk); lk_valid = 0; lk_write = 0; lk_user = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      tag = "R1";
      repeat (2) @(negedge clk);
      look(32'h0000_0000, 0, 0);
      look(32'h8000_1000, 0, 0);

      tag = "R9";  put(6'd3, 20'h12345, 6'd5, 20'hABCDE, 4'b0110);
      tag = "R4";  look(32'h1234_5678, 0, 1);
      look(32'h1234_5FFF, 1, 0);
      tag = "R5";  set_hi(20'h0, 6'd6); look(32'h1234_5678, 0, 1);
      tag = "R4";  put(6'd10, 20'h00042, 6'd9, 20'h00777, 4'b0111);
      set_hi(20'h0, 6'd1); look(32'h0004_2ABC, 0, 1);
      tag = "R6";  put(6'd11, 20'h00050, 6'd1, 20'h00001, 4'b0100);
      look(32'h0005_0000, 0, 1);
      put(6'd12, 20'h80060, 6'd1, 20'h00009, 4'b0100);
      look(32'h8006_0010, 0, 0);
      tag = "R7";  put(6'd13, 20'h00070, 6'd1, 20'h00002, 4'b0010);
      look(32'h0007_0040, 1, 1);
      look(32'h0007_0040, 0, 1);
      tag = "R8";  put(6'd14, 20'h00080, 6'd1, 20'h00003, 4'b1110);
      look(32'h0008_0123, 0, 1);
      look(32'h0008_0123, 1, 1);
      tag = "R3";  look(32'h8006_0010, 0, 1);
      look(32'hFFFF_F000, 1, 1);
      tag = "R5";  look(32'h9000_0000, 0, 0);
      look(32'h0FFF_0000, 1, 1);
      put(6'd15, 20'h80090, 6'd1, 20'h00004, 4'b0110);
      look(32'h8009_0123, 0, 0);
      tag = "R12"; put(6'd30, 20'h000A0, 6'd1, 20'h00030, 4'b0110);
      put(6'd20, 20'h000A0, 6'd1, 20'h00020, 4'b0110);
      look(32'h000A_0555, 0, 1);
      tag = "R11"; set_hi(20'h000A0, 6'd1); cmd(2'd3);
      set_hi(20'h0DEAD, 6'd1); cmd(2'd3);
      set_idx(6'd5);
      set_hi(20'h00042, 6'd33); cmd(2'd3);
      tag = "R12"; put(6'd20, 20'h000A0, 6'd1, 20'h00020, 4'b0100);
      look(32'h000A_0555, 0, 1);
      tag = "R9";  set_idx(6'd13); cmd(2'd2);
      ehi_we = 1; ehi_wdata = 26'h3FF_FFFF; elo_we = 1; elo_wdata = 24'hFF_FFFF;
      cmd(2'd2); ehi_we = 0; elo_we = 0;
      tag = "R10"; set_hi(20'h000B0, 6'd1); set_lo(20'h00055, 4'b0110);
      for (int k = 0; k < 70; k++) begin
         cmd(2'd1);
         cmd(2'd3);
      end
      look(32'h000B_0001, 0, 1);

      tag = "R2";
      for (int k = 0; k < 3000; k++) begin
         lk_valid  = ($urandom % 3) != 0;
         lk_vaddr  = {1'($urandom), 11'd0, 8'($urandom % 6), 12'($urandom)};
         lk_write  = 1'($urandom);
         lk_user   = 1'($urandom);
         cmd_valid = ($urandom % 4) == 0;
         cmd_op    = 2'($urandom);
         ehi_we    = ($urandom % 3) == 0;
         ehi_wdata = {1'($urandom), 11'd0, 8'($urandom % 6), 6'($urandom % 3)};
         elo_we    = ($urandom % 3) == 0;
         elo_wdata = {20'($urandom), 4'($urandom)};
         idx_we    = ($urandom % 5) == 0;
         idx_wdata = 6'($urandom);
         @(negedge clk);
      end
      lk_valid = 0; cmd_valid = 0; ehi_we = 0; elo_we = 0; idx_we = 0;
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule